// File: doc/BRIEF.md
# Word-Wide One-Time-Programmable Memory Emulator

This block is a synthesizable stand-in for a 16-bit-wide one-time-programmable memory. The array depth comes from an address-width parameter. Every clock cycle the block looks at five active-low and flag inputs and picks one behaviour:

- the two active-low enables, for the chip and for the output;
- an active-low program strobe;
- a flag saying the programming supply is present;
- a flag saying a high voltage sits on the identification address pin.

The behaviour it picks is one of:

- read;
- output disable;
- standby;
- program;
- program verify;
- program inhibit;
- product identification.

The bidirectional data bus is split into `din`, `dout` and an output-enable `dout_en`. A system model or a bus wrapper turns these into a tristate bus when one is needed. Analog supply levels become single-bit flags, and access time becomes a parameterized number of clock cycles (`LAT_CYC`, default 1). The array starts erased. A program operation can only clear bits, so the stored word is ANDed with the input data.

Top module: `word_prom_emu`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0, `vpp_hi`=0 and `id_hv`=0, `LAT_CYC` cycles later `dout_en`=1 and `dout` holds the word stored at `addr`.
- R2: With `ce_n`=1 and `vpp_hi`=0 (standby), `dout_en` is 0 and no word changes, even with `pgm_n`=0.
- R3: With `ce_n`=0, `oe_n`=1 and `vpp_hi`=0 (output disable), `dout_en` is 0 and no word changes, even with `pgm_n`=0 or `id_hv`=1.
- R4: With `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0, the word at `addr` is written at the clock edge, and `dout_en` is 0.
- R5: With `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1, `dout_en`=1 and `dout` holds the stored word at `addr` (verify).
- R6: With `vpp_hi`=1 and `ce_n`=1 (program inhibit), `dout_en` is 0 and no word changes.
- R7: With `id_hv`=1, `vpp_hi`=0, `ce_n`=0 and `oe_n`=0, `dout` returns 0x001E when `addr` bit 0 is 0 and 0x00F7 when it is 1, whatever the other address bits are.
- R8: After reset every word reads 0xFFFF and `dout_en` is 0.
- R9: A write stores the old word AND `din`, so a bit at 0 never returns to 1.
- R10: `dout` is 0 whenever `dout_en` is 0. Outputs follow the inputs after exactly `LAT_CYC` clock edges.
- R11: With `vpp_hi`=1 and `ce_n`=0, the pairs `oe_n`=`pgm_n`=0 and `oe_n`=`pgm_n`=1 give `dout_en`=0 and change no word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply present |
| id_hv | input | 1 | High voltage on the identification pin |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Data to program |
| dout | output | DATA_W | Data read out; 0 when not driven |
| dout_en | output | 1 | Data bus drive enable |

## Verification
With the default latency, each output result is due one rising edge after its inputs are applied. A write lands on that same edge, so a read or verify issued in the next cycle already sees the new word. The bench applies each stimulus at a falling edge and samples one falling edge later, with exactly one rising edge in between. One check samples just after a change of inputs, before any edge, to confirm the old output is still held. Each claim that a mode leaves the array alone is followed by a read or verify of the touched address.

// File: rtl/word_prom_emu.sv
module word_prom_emu #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LAT_CYC = 1,
  parameter logic [DATA_W-1:0] MFR_CODE = 'h001E,
  parameter logic [DATA_W-1:0] DEV_CODE = 'h00F7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {
    M_STBY, M_INHIB, M_DIS, M_READ, M_IDENT, M_PROG, M_VER
  } mode_t;

  mode_t mode;
  logic [DATA_W-1:0] mem [DEPTH];
  logic              rd_en;
  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] out_word;

  always_comb begin
    if (ce_n)
      mode = vpp_hi ? M_INHIB : M_STBY;
    else if (vpp_hi) begin
      if (oe_n && !pgm_n)      mode = M_PROG;
      else if (!oe_n && pgm_n) mode = M_VER;
      else                     mode = M_DIS;
    end else if (oe_n)
      mode = M_DIS;
    else
      mode = id_hv ? M_IDENT : M_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (mode == M_PROG) begin
      mem[addr] <= mem[addr] & din;
    end
  end

  assign rd_en    = (mode == M_READ) || (mode == M_VER) || (mode == M_IDENT);
  assign rd_word  = (mode == M_IDENT) ? (addr[0] ? DEV_CODE : MFR_CODE) : mem[addr];
  assign out_word = rd_en ? rd_word : '0;

  generate
    if (LAT_CYC == 0) begin : g_comb
      assign dout    = out_word;
      assign dout_en = rd_en;
    end else begin : g_pipe
      logic [DATA_W-1:0] pipe_d [LAT_CYC];
      logic [LAT_CYC-1:0] pipe_e;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < LAT_CYC; i++) pipe_d[i] <= '0;
          pipe_e <= '0;
        end else begin
          pipe_d[0] <= out_word;
          pipe_e[0] <= rd_en;
          for (int i = 1; i < LAT_CYC; i++) begin
            pipe_d[i] <= pipe_d[i-1];
            pipe_e[i] <= pipe_e[i-1];
          end
        end
      end
      assign dout    = pipe_d[LAT_CYC-1];
      assign dout_en = pipe_e[LAT_CYC-1];
    end
  endgenerate

endmodule

// File: rtl/word_prom_emu_chk.sv
module word_prom_emu_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LAT_CYC = 1,
  parameter logic [DATA_W-1:0] MFR_CODE = 'h001E,
  parameter logic [DATA_W-1:0] DEV_CODE = 'h00F7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              vpp_hi,
  input logic              id_hv,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);

  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == '0); // R10

  generate
    if (LAT_CYC == 1) begin : g_lat1
      AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !vpp_hi) |=> dout_en); // R1
      AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_en); // R2
      AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && oe_n) |=> !dout_en); // R3
      AST_VERIFY_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_hi && !ce_n && !oe_n && pgm_n) |=> dout_en); // R5
      AST_ID_MFR: assert property (@(posedge clk) disable iff (!rst_n)
        (id_hv && !vpp_hi && !ce_n && !oe_n && !addr[0]) |=> dout == MFR_CODE); // R7
      AST_ID_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        (id_hv && !vpp_hi && !ce_n && !oe_n && addr[0]) |=> dout == DEV_CODE); // R7
    end
  endgenerate

endmodule

bind word_prom_emu word_prom_emu_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_CYC(LAT_CYC),
  .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
  .vpp_hi(vpp_hi), .id_hv(id_hv), .addr(addr), .din(din),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/test_word_prom_emu.sv
module test_word_prom_emu;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic ce_n = 1, oe_n = 1, pgm_n = 1, vpp_hi = 0, id_hv = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  word_prom_emu #(.ADDR_W(AW), .DATA_W(DW)) i_word_prom_emu (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .id_hv(id_hv), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(string tag, logic en_exp, logic [DW-1:0] d_exp);
    checks++;
    if (dout_en !== en_exp || dout !== d_exp) begin
      errors++;
      $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
               tag, dout_en, dout, en_exp, d_exp);
    end
  endtask

  // apply at a falling edge, sample at the next falling edge (one rising edge between)
  task automatic cyc(logic c, logic o, logic p, logic v, logic i,
                     logic [AW-1:0] a, logic [DW-1:0] d);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = v; id_hv = i; addr = a; din = d;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk); check("R8 reset quiet", 0, '0);
    rst_n = 1;
    @(negedge clk); check("R8 quiet after reset", 0, '0);
    cyc(0, 0, 1, 0, 0, 6'd5, '0);  check("R8 erased word 5", 1, 16'hFFFF);
    cyc(0, 0, 1, 0, 0, 6'd63, '0); check("R8 erased word 63", 1, 16'hFFFF);
  endtask

  task automatic t_program();
    cyc(0, 1, 0, 1, 0, 6'd3, 16'hA5F0); check("R4 program quiet", 0, '0);
    cyc(0, 0, 1, 1, 0, 6'd3, '0);       check("R5 verify word 3", 1, 16'hA5F0);
    cyc(0, 1, 0, 1, 0, 6'd3, 16'h0FFF); check("R4 reprogram quiet", 0, '0);
    cyc(0, 0, 1, 1, 0, 6'd3, '0);       check("R9 bits only clear", 1, 16'h05F0);
    cyc(0, 0, 1, 0, 0, 6'd3, '0);       check("R1 read word 3", 1, 16'h05F0);
    cyc(0, 0, 1, 0, 0, 6'd4, '0);       check("R1 neighbour untouched", 1, 16'hFFFF);
  endtask

  task automatic t_latency();
    cyc(1, 1, 1, 0, 0, 6'd0, '0); check("R10 standby before", 0, '0);
    ce_n = 0; oe_n = 0; addr = 6'd3;
    #1 check("R10 held before edge", 0, '0);
    @(negedge clk); check("R10 one edge later", 1, 16'h05F0);
  endtask

  task automatic t_standby();
    cyc(1, 0, 0, 0, 0, 6'd3, 16'h0000); check("R2 standby quiet", 0, '0);
    cyc(0, 0, 1, 0, 0, 6'd3, '0);       check("R2 no write in standby", 1, 16'h05F0);
  endtask

  task automatic t_disable();
    cyc(0, 1, 0, 0, 0, 6'd3, 16'h0000); check("R3 disable quiet", 0, '0);
    cyc(0, 1, 1, 0, 1, 6'd0, '0);       check("R3 disable with id", 0, '0);
    cyc(0, 0, 1, 0, 0, 6'd3, '0);       check("R3 no write in disable", 1, 16'h05F0);
  endtask

  task automatic t_inhibit();
    cyc(1, 1, 0, 1, 0, 6'd3, 16'h0000); check("R6 inhibit quiet", 0, '0);
    cyc(1, 0, 1, 1, 0, 6'd3, 16'h0000); check("R6 inhibit oe low quiet", 0, '0);
    cyc(0, 0, 1, 1, 0, 6'd3, '0);       check("R6 no write in inhibit", 1, 16'h05F0);
  endtask

  task automatic t_odd_combos();
    cyc(0, 0, 0, 1, 0, 6'd3, 16'h0000); check("R11 oe0 pgm0 quiet", 0, '0);
    cyc(0, 1, 1, 1, 0, 6'd3, 16'h0000); check("R11 oe1 pgm1 quiet", 0, '0);
    cyc(0, 0, 1, 1, 0, 6'd3, '0);       check("R11 no write", 1, 16'h05F0);
  endtask

  task automatic t_ident();
    cyc(0, 0, 1, 0, 1, 6'd0, '0);  check("R7 manufacturer code", 1, 16'h001E);
    cyc(0, 0, 1, 0, 1, 6'd1, '0);  check("R7 device code", 1, 16'h00F7);
    cyc(0, 0, 1, 0, 1, 6'h3E, '0); check("R7 upper bits ignored 0", 1, 16'h001E);
    cyc(0, 0, 1, 0, 1, 6'h3F, '0); check("R7 upper bits ignored 1", 1, 16'h00F7);
    cyc(0, 0, 1, 0, 0, 6'd3, '0);  check("R1 read after id", 1, 16'h05F0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_program();
    t_latency();
    t_standby();
    t_disable();
    t_inhibit();
    t_odd_combos();
    t_ident();
    cyc(1, 1, 1, 0, 0, '0, '0); check("R2 final standby", 0, '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule